// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable, cycle-level model of a synchronous static RAM used as a processor-side cache store. The rising clock edge captures the address, write data and every control input. The exceptions are output enable, sleep and the burst-order select, which act combinationally. Either of two start strobes opens an access at a new external address. One strobe belongs to the processor and the other to the cache controller. Later beats of a four-beat burst come from an internal two-bit counter, which moves only on edges where the advance input is high. The order of the low address bits is linear or interleaved, chosen by a static select.

Writes use one decode built from per-lane write strobes, a write enable and a global write. The write happens on the same clock edge, with no external pulse. Reads flow through: the word at the registered address reaches the output in the cycle after the capturing edge, with no output register. A deselect takes effect after a single edge. The word is made of 9-bit lanes, four by default or two for the narrow form; the narrow form is meant to be built with one more address bit. Depth is a parameter so the model stays small in simulation. Instead of a tri-state bus, the block has a data output and a separate drive flag. A low drive flag stands for high impedance.

Top module: `burst_sram`

## Requirements
- R1: With chip enable high, an edge with the processor strobe high loads the external address as beat 0 and performs a read. No lane is written on that edge, whatever the write inputs are.
- R2: With chip enable high and the processor strobe not taking effect, an edge with the controller strobe high loads the external address as beat 0 and writes the decoded lanes there. While a burst is selected, a later edge with neither strobe writes the decoded lanes at the address the burst moves to on that edge.
- R3: While selected, the beat counter moves up by one (modulo 4) only on an edge with the advance input high, and holds its value otherwise.
- R4: With the order select low (linear), the low two bits of the access address are (start + beat) mod 4. The upper bits stay those of the start address.
- R5: With the order select high (interleaved), the low two bits of the access address are start XOR beat.
- R6: Lane i is the data bits [9i+8:9i]. With the write enable high, lane i is written only when lane strobe bit i is high. Other lanes keep their contents.
- R7: With both the write enable and the global write low, no lane is written, whatever the lane strobes are.
- R8: With the global write high, all lanes are written, whatever the lane strobes and write enable are.
- R9: Read data is the array word at the current access address, with no output register. A change of the order select changes the read address without a clock edge.
- R10: An edge with the controller strobe high, chip enable low and the processor strobe not taking effect deselects the block. The drive flag is low from that edge on.
- R11: When both strobes are high with chip enable high, the processor strobe wins and the cycle is a read. With chip enable low, the processor strobe is ignored and an open burst continues.
- R12: While sleep is high, every clock edge is ignored, the contents are held, and the drive flag is low.
- R13: The drive flag is high only when the block is selected, output enable is high, sleep is low and the last edge wrote nothing. Output enable acts without a clock edge.
- R14: After reset the block is deselected and the drive flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state (not the array) |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data |
| proc_start | input | 1 | Processor-side burst start strobe |
| ctrl_start | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Burst advance |
| order_ilv | input | 1 | Burst order select, 0 linear, 1 interleaved (asynchronous) |
| lane_we | input | LANES | Per-lane write strobes |
| all_we | input | 1 | Global write, all lanes |
| we | input | 1 | Write enable qualifying the lane strobes |
| ce | input | 1 | Chip enable, sampled with a start strobe |
| oe | input | 1 | Output enable (asynchronous) |
| sleep | input | 1 | Sleep, freezes the block and turns the output off |
| dq_out | output | LANES*LANE_W | Flow-through read data |
| dq_drive | output | 1 | High when the data output is driven, low for high impedance |

## Verification
A table of single-edge writes mixes lane strobe masks, write enable and global write over a known background word. Each result is read back, which separates per-lane qualification from the global override and shows that strobes without an enable do nothing. Linear and interleaved read bursts start from an unaligned address. They show the wrap of the low bits, the difference between add and XOR stepping, and the hold when advance is low. Toggling the order select between edges shows that the read address follows it without a clock. Strobe conflicts, a chip-enable-low processor strobe, a deselect, sleep with a pending write, and a write burst that continues with advance each cover one ordering rule in turn.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Low two address bits of a burst beat: linear adds, interleaved XORs.
  function automatic logic [1:0] burst_seq(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

  // Write qualification for one lane.
  function automatic logic lane_hit(input logic en, input logic all_w,
                                    input logic wen, input logic strobe);
    return en & (all_w | (wen & strobe));
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce,
  input  logic              proc_start,
  input  logic              ctrl_start,
  input  logic              adv,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_fire,
  output logic              sel_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok,
  output logic              proc_go,
  output logic              load_evt,
  output logic              step_evt
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nxt;
  logic            ctrl_go;
  logic            desel_evt;

  // Named events used by the logic below and by the assertions.
  assign proc_go   = proc_start & ce & ~sleep;
  assign ctrl_go   = ctrl_start & ~proc_go & ~sleep;
  assign load_evt  = proc_go | (ctrl_go & ce);
  assign desel_evt = ctrl_go & ~ce;
  assign step_evt  = ~sleep & ~proc_go & ~ctrl_go & sel_q & adv;
  assign cnt_nxt   = cnt_q + 2'd1;

  assign wr_ok = ~sleep & ~proc_go & ((ctrl_go & ce) | (~ctrl_go & sel_q));

  assign rd_addr = {hi_q, burst_seq(base_q, cnt_q, order_ilv)};
  assign wr_addr = load_evt ? addr
                 : {hi_q, burst_seq(base_q, step_evt ? cnt_nxt : cnt_q, order_ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (!sleep) begin
      wr_q <= wr_fire;
      if (load_evt) begin
        hi_q   <= addr[ADDR_W-1:2];
        base_q <= addr[1:0];
        cnt_q  <= 2'd0;
        sel_q  <= 1'b1;
      end else if (desel_evt) begin
        sel_q <= 1'b0;
      end else if (step_evt) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  AST_LOAD_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == 2'd0) && sel_q); // R1
  AST_DESELECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_start && !ce && !sleep) |=> !sel_q); // R10
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_start && !ctrl_start && !adv) |=> $stable(cnt_q)); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && sel_q && !proc_start && !ctrl_start && adv)
      |=> cnt_q == $past(cnt_q) + 2'd1); // R3
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cnt_q) && $stable(sel_q) && $stable(hi_q)); // R12

endmodule

// File: rtl/burst_sram_wdec.sv
module burst_sram_wdec
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             enable,
  input  logic             all_we,
  input  logic             we,
  input  logic [LANES-1:0] lane_we,
  output logic [LANES-1:0] wr_mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_mask[i] = lane_hit(enable, all_we, we, lane_we[i]);
  end

  always_comb begin
    AST_ALL_LANES: assert (!(enable && all_we) || (&wr_mask)); // R8
  end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[i]) mem[wr_addr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    proc_start,
  input  logic                    ctrl_start,
  input  logic                    adv,
  input  logic                    order_ilv,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    all_we,
  input  logic                    we,
  input  logic                    ce,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  logic              sel_q, wr_q, wr_ok, proc_go, load_evt, step_evt;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic              wr_fire;

  assign wr_fire = |wr_mask;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce(ce),
    .proc_start(proc_start), .ctrl_start(ctrl_start), .adv(adv),
    .order_ilv(order_ilv), .addr(addr), .wr_fire(wr_fire),
    .sel_q(sel_q), .wr_q(wr_q), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .wr_ok(wr_ok), .proc_go(proc_go), .load_evt(load_evt), .step_evt(step_evt)
  );

  burst_sram_wdec #(.LANES(LANES)) wdec_i (
    .enable(wr_ok), .all_we(all_we), .we(we), .lane_we(lane_we),
    .wr_mask(wr_mask)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .wr_mask(wr_mask), .wr_addr(wr_addr), .wdata(din),
    .rd_addr(rd_addr), .rdata(dq_out)
  );

  assign dq_drive = sel_q & oe & ~sleep & ~wr_q;

  AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start && ce |-> wr_mask == '0); // R1
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> wr_mask == '0 && !dq_drive); // R12
  AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !all_we) |-> wr_mask == '0); // R7
  AST_WRITE_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != '0) |=> !dq_drive); // R13

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          proc_start, ctrl_start, adv, order_ilv, all_we, we, ce, oe, sleep;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .proc_start(proc_start), .ctrl_start(ctrl_start), .adv(adv),
    .order_ilv(order_ilv), .lane_we(lane_we), .all_we(all_we), .we(we),
    .ce(ce), .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  // {lane_we, all_we, we, addr, data}
  localparam logic [49:0] VEC [8] = '{
    {4'b0001, 1'b0, 1'b1, 8'h50, 36'h123456789},
    {4'b1010, 1'b0, 1'b1, 8'h51, 36'hFEDCBA987},
    {4'b1111, 1'b0, 1'b1, 8'h52, 36'hABCDEF012},
    {4'b0000, 1'b1, 1'b0, 8'h53, 36'h0F0F0F0F0},
    {4'b0110, 1'b0, 1'b0, 8'h54, 36'h555555555},
    {4'b0101, 1'b1, 1'b0, 8'h55, 36'h3C3C3C3C3},
    {4'b1000, 1'b0, 1'b1, 8'h56, 36'h999999999},
    {4'b0000, 1'b0, 1'b1, 8'h57, 36'h777777777}
  };
  localparam logic [DW-1:0] BG = {4{9'h1A5}};

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {4{1'b0, a}};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    proc_start = 0; ctrl_start = 0; adv = 0; lane_we = '0;
    all_we = 0; we = 0; ce = 1;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ctrl_start = 1; ce = 1; addr = a; din = d; all_we = 1;
    tick(); clr();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    proc_start = 1; ce = 1; addr = a;
    tick(); clr();
  endtask

  initial begin
    #(20ns * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; addr = '0; din = '0; order_ilv = 0; oe = 1; sleep = 0;
    clr();
    repeat (3) tick();
    chk("R14 drive after reset", {35'd0, dq_drive}, 36'd0);
    rst_n = 1;
    tick();

    // Table of single-edge writes over a background word (R6 R7 R8 R2)
    for (int k = 0; k < 8; k++) begin
      logic [DW-1:0] exp;
      put(VEC[k][43:36], BG);
      ctrl_start = 1; ce = 1; addr = VEC[k][43:36]; din = VEC[k][35:0];
      lane_we = VEC[k][49:46]; all_we = VEC[k][45]; we = VEC[k][44];
      tick(); clr();
      for (int i = 0; i < NL; i++)
        exp[i*LW +: LW] = (VEC[k][45] || (VEC[k][44] && VEC[k][46+i]))
                          ? VEC[k][i*LW +: LW] : BG[i*LW +: LW];
      rd(VEC[k][43:36]);
      chk("R6/R7/R8 lane write table", dq_out, exp);
    end

    for (int a = 'h10; a <= 'h13; a++) put(AW'(a), pat(AW'(a)));
    for (int a = 'h20; a <= 'h23; a++) put(AW'(a), pat(AW'(a)));

    // R1 R4 R3: linear burst from 0x12
    order_ilv = 0;
    rd(8'h12);
    chk("R1 processor start read", dq_out, pat(8'h12));
    chk("R1 drive on read", {35'd0, dq_drive}, 36'd1);
    adv = 1; tick(); chk("R4 linear beat1", dq_out, pat(8'h13));
    tick(); chk("R4 linear beat2 wrap", dq_out, pat(8'h10));
    tick(); chk("R4 linear beat3", dq_out, pat(8'h11));
    tick(); chk("R3 counter wraps mod 4", dq_out, pat(8'h12));
    adv = 0; tick(); chk("R3 hold without advance", dq_out, pat(8'h12));

    // R9: order select acts without a clock
    rd(8'h11);
    adv = 1; tick(); adv = 0;
    chk("R9 linear start1 beat1", dq_out, pat(8'h12));
    order_ilv = 1; #1;
    chk("R9 order change is asynchronous", dq_out, pat(8'h10));

    // R5: interleaved burst from 0x21
    rd(8'h21);
    chk("R5 interleaved beat0", dq_out, pat(8'h21));
    adv = 1; tick(); chk("R5 interleaved beat1", dq_out, pat(8'h20));
    tick(); chk("R5 interleaved beat2", dq_out, pat(8'h23));
    tick(); chk("R5 interleaved beat3", dq_out, pat(8'h22));
    adv = 0; order_ilv = 0;

    // R13: output enable and write cycle
    rd(8'h10);
    oe = 0; #1; chk("R13 oe low turns drive off", {35'd0, dq_drive}, 36'd0);
    oe = 1; #1; chk("R13 oe high turns drive on", {35'd0, dq_drive}, 36'd1);
    ctrl_start = 1; addr = 8'h30; din = 36'hACE0BD123; all_we = 1;
    tick(); clr();
    chk("R13 drive off after write edge", {35'd0, dq_drive}, 36'd0);
    rd(8'h30); chk("R2 controller start write", dq_out, 36'hACE0BD123);

    // R10: single-cycle deselect
    rd(8'h10);
    ctrl_start = 1; ce = 0; tick(); clr();
    chk("R10 deselect after one edge", {35'd0, dq_drive}, 36'd0);
    tick(); chk("R10 stays deselected", {35'd0, dq_drive}, 36'd0);

    // R11: processor strobe priority and chip-enable gating
    proc_start = 1; ctrl_start = 1; ce = 1; addr = 8'h13; din = 36'h0DEADBEEF;
    all_we = 1; tick(); clr();
    chk("R11 both strobes read", dq_out, pat(8'h13));
    chk("R11 both strobes drive", {35'd0, dq_drive}, 36'd1);
    proc_start = 1; ce = 0; addr = 8'h20; tick(); clr();
    chk("R11 processor strobe ignored with ce low", dq_out, pat(8'h13));

    // R12: sleep freezes everything
    sleep = 1; #1;
    chk("R12 drive off in sleep", {35'd0, dq_drive}, 36'd0);
    ctrl_start = 1; addr = 8'h10; din = 36'h111111111; all_we = 1;
    tick(); clr(); sleep = 0; #1;
    chk("R12 selection held over sleep", dq_out, pat(8'h13));
    rd(8'h10); chk("R12 contents held", dq_out, pat(8'h10));

    // R2: write burst continued with advance
    put(8'h40, 36'h000000AAA);
    adv = 1; we = 1; lane_we = 4'b1111; din = 36'h000000BBB; tick(); clr();
    rd(8'h41); chk("R2 burst write at advanced address", dq_out, 36'h000000BBB);
    rd(8'h40); chk("R2 first beat kept", dq_out, 36'h000000AAA);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule